// File: doc/BRIEF.md
# Grouped-Step Instruction Fetch Sequencer

This block is the fetch-phase controller and register datapath of a small accumulator-style processor. It owns the program counter, the memory address register, the memory buffer register and the instruction register. It drives a synchronous single-port memory that has one cycle of read latency. Each step of the sequence lasts one clock cycle. Transfers that do not depend on each other share a step: the PC increments in the same step as the instruction read, and the PC is saved in the same step that the MAR is loaded with the save slot. Transfers that depend on each other always fall in separate, ordered steps.

A 16-bit instruction has a 4-bit opcode in bits 15:12, a mode flag in bit 11 and an 11-bit field in bits 10:0. When the flag is 1, the field is the operand itself and no further memory access is made. When the flag is 0, the field is an address, and an extra memory round fetches the operand word. After each complete instruction the interrupt request is sampled. If it is taken, the next PC is written to memory address 0 through the MBR, and fetching resumes at address 1.

Top module: `fetch_seq`

## Requirements
- R1: While `rst_n` is low, `pc`, `instr`, `mem_rd`, `mem_wr`, `fetch_done` and `irq_ack` are all zero. After release, the first instruction is fetched from address 0.
- R2: In the first step of each instruction, the MAR is loaded from the PC. The first memory read of an instruction presents `mem_addr` equal to the PC value before that instruction's increment.
- R3: The PC increments by one, modulo 2^11, in the same step that issues the instruction read. At `fetch_done`, `pc` equals the fetched instruction's address plus one.
- R4: Read data is captured into the MBR in the step after the read strobe. It moves to the IR only in a later step, so `instr` still holds the previous instruction during the capture step.
- R5: When bit 11 of the instruction is 1, the operand is the zero-extended field in bits 10:0. Exactly one memory read is made, and `fetch_done` comes 5 cycles after the previous `fetch_done`.
- R6: When bit 11 is 0, a second read is made at the address in bits 10:0, and the word read becomes the operand. There are two reads in total, and `fetch_done` comes 8 cycles after the previous one.
- R7: `fetch_done` is a single-cycle pulse. While it is high, `instr` holds the full fetched instruction and `operand` holds the resolved operand.
- R8: `irq` is sampled only in the `fetch_done` step. A request raised in the middle of a fetch does not change that fetch's length, reads or results.
- R9: A taken interrupt raises `irq_ack` in the cycle after `fetch_done`. The next cycle writes the saved PC (`mem_wr`, `mem_addr` = 0, `mem_wdata` = the PC after increment). The PC then becomes 1, and the next fetch starts 2 cycles later than it would have.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| irq | input | 1 | Interrupt request level |
| mem_rdata | input | 16 | Read data, valid one cycle after `mem_rd` |
| mem_addr | output | 11 | Memory address (the MAR) |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data (the MBR) |
| instr | output | 16 | Instruction register |
| operand | output | 16 | Resolved operand, valid with `fetch_done` |
| fetch_done | output | 1 | Pulse: instruction and operand valid |
| irq_ack | output | 1 | Pulse: interrupt taken |
| pc | output | 11 | Program counter |

## Verification
Almost any wrong step ordering or wrong step-state decode shows at the ports within a single instruction. Typical symptoms are a `fetch_done` that comes a cycle early or late, a read count other than one or two, a first read at the wrong address, or an `instr` value that changes in the capture step. A wrong PC increment or a stale MBR appears at the very next `fetch_done`, as a mismatch of `pc`, `instr` or `operand` against the bench's own memory image. A fault in the interrupt path shows within two cycles, as a misplaced `irq_ack`, a wrong saved value or address on the write, or a next fetch that does not start at address 1.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  typedef enum logic [3:0] {
    ST_ADDR   = 4'd0,
    ST_READ   = 4'd1,
    ST_CAPT   = 4'd2,
    ST_LOAD   = 4'd3,
    ST_OPADDR = 4'd4,
    ST_OPREAD = 4'd5,
    ST_OPCAPT = 4'd6,
    ST_DONE   = 4'd7,
    ST_SAVE   = 4'd8,
    ST_VECT   = 4'd9
  } step_e;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_ir;
    logic mar_to_save;
    logic mbr_from_mem;
    logic mbr_from_pc;
    logic ir_from_mbr;
    logic pc_inc;
    logic pc_to_vec;
  } xfer_t;

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
  import fetch_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  imm_flag,
  input  logic  irq,
  output step_e step,
  output xfer_t xfer,
  output logic  mem_rd,
  output logic  mem_wr,
  output logic  fetch_done,
  output logic  irq_ack
);

  step_e step_q, step_d;

  always_comb begin
    step_d     = step_q;
    xfer       = '0;
    mem_rd     = 1'b0;
    mem_wr     = 1'b0;
    fetch_done = 1'b0;
    irq_ack    = 1'b0;
    case (step_q)
      ST_ADDR: begin
        xfer.mar_from_pc = 1'b1;
        step_d = ST_READ;
      end
      ST_READ: begin
        mem_rd      = 1'b1;
        xfer.pc_inc = 1'b1;
        step_d = ST_CAPT;
      end
      ST_CAPT: begin
        xfer.mbr_from_mem = 1'b1;
        step_d = ST_LOAD;
      end
      ST_LOAD: begin
        xfer.ir_from_mbr = 1'b1;
        step_d = imm_flag ? ST_DONE : ST_OPADDR;
      end
      ST_OPADDR: begin
        xfer.mar_from_ir = 1'b1;
        step_d = ST_OPREAD;
      end
      ST_OPREAD: begin
        mem_rd = 1'b1;
        step_d = ST_OPCAPT;
      end
      ST_OPCAPT: begin
        xfer.mbr_from_mem = 1'b1;
        step_d = ST_DONE;
      end
      ST_DONE: begin
        fetch_done = 1'b1;
        step_d = irq ? ST_SAVE : ST_ADDR;
      end
      ST_SAVE: begin
        irq_ack          = 1'b1;
        xfer.mbr_from_pc = 1'b1;
        xfer.mar_to_save = 1'b1;
        step_d = ST_VECT;
      end
      ST_VECT: begin
        mem_wr         = 1'b1;
        xfer.pc_to_vec = 1'b1;
        step_d = ST_ADDR;
      end
      default: step_d = ST_ADDR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_ADDR;
    else        step_q <= step_d;
  end

  assign step = step_q;

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> !fetch_done);
  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  assert_ack_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> $past(fetch_done));

endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
  import fetch_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 16,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  xfer_t         xfer,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] mar_q,
  output logic [DW-1:0] mbr_q,
  output logic [DW-1:0] ir_q
);

  logic [AW-1:0] pc_d, mar_d;
  logic [DW-1:0] mbr_d, ir_d;
  logic          pc_en, mar_en, mbr_en, ir_en;

  assign pc_en  = xfer.pc_inc | xfer.pc_to_vec;
  assign mar_en = xfer.mar_from_pc | xfer.mar_from_ir | xfer.mar_to_save;
  assign mbr_en = xfer.mbr_from_mem | xfer.mbr_from_pc;
  assign ir_en  = xfer.ir_from_mbr;

  always_comb begin
    pc_d = AW'(VEC_ADDR);
    if (xfer.pc_inc) pc_d = pc_q + AW'(1);

    mar_d = AW'(SAVE_ADDR);
    if (xfer.mar_from_pc)      mar_d = pc_q;
    else if (xfer.mar_from_ir) mar_d = ir_q[AW-1:0];

    mbr_d = {{(DW-AW){1'b0}}, pc_q};
    if (xfer.mbr_from_mem) mbr_d = mem_rdata;

    ir_d = mbr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (pc_en)  pc_q  <= pc_d;
      if (mar_en) mar_q <= mar_d;
      if (mbr_en) mbr_q <= mbr_d;
      if (ir_en)  ir_q  <= ir_d;
    end
  end

endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
  import fetch_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 16,
  parameter int SAVE_ADDR = 0,
  parameter int VEC_ADDR  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          irq,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] instr,
  output logic [DW-1:0] operand,
  output logic          fetch_done,
  output logic          irq_ack,
  output logic [AW-1:0] pc
);

  localparam int FLAG_BIT = AW;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  step_e         step;
  xfer_t         xfer;
  logic [AW-1:0] pc_q, mar_q;
  logic [DW-1:0] mbr_q, ir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fetch_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .imm_flag   (mbr_q[FLAG_BIT]),
    .irq        (irq),
    .step       (step),
    .xfer       (xfer),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .fetch_done (fetch_done),
    .irq_ack    (irq_ack)
  );

  fetch_regs #(
    .AW        (AW),
    .DW        (DW),
    .SAVE_ADDR (SAVE_ADDR),
    .VEC_ADDR  (VEC_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .xfer      (xfer),
    .mem_rdata (mem_rdata),
    .pc_q      (pc_q),
    .mar_q     (mar_q),
    .mbr_q     (mbr_q),
    .ir_q      (ir_q)
  );

  assign mem_addr  = mar_q;
  assign mem_wdata = mbr_q;
  assign instr     = ir_q;
  assign pc        = pc_q;
  assign operand   = ir_q[FLAG_BIT] ? {{(DW-AW){1'b0}}, ir_q[AW-1:0]} : mbr_q;

  assert_read_addr_is_pc_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step == ST_READ) |-> (mem_addr == pc_q));
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step == ST_READ) |=> (pc_q == $past(pc_q) + AW'(1)));
  assert_ir_after_mbr_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (step == ST_LOAD) |=> (ir_q == $past(mbr_q)));
  assert_save_write_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_wr |-> (mem_addr == AW'(SAVE_ADDR)));
  assert_vector_load_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_wr |=> (pc_q == AW'(VEC_ADDR)));

endmodule

// File: tb/fetch_seq_tb.sv
`timescale 1ns/1ps
module fetch_seq_tb;

  localparam int AW = 11;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          irq;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata, instr, operand;
  logic          fetch_done, irq_ack;
  logic [AW-1:0] pc;

  logic [DW-1:0] mem [DEPTH];

  int total = 0;
  int bad = 0;
  int dones = 0;
  int cyc = 0;
  int rd_cnt = 0;
  bit first = 1'b1;
  bit taken = 1'b0;
  bit prev_done = 1'b0;
  bit chk_capt = 1'b0;
  int irq_gap = 0;
  logic [AW-1:0] pc_exp = '0;
  logic [AW-1:0] save_exp = '0;
  logic [DW-1:0] last_instr = '0;

  always #4 clk = ~clk;

  fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .irq(irq), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .instr(instr), .operand(operand), .fetch_done(fetch_done),
    .irq_ack(irq_ack), .pc(pc)
  );

  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [DW-1:0] iw;
    logic [DW-1:0] op_exp;
    int len_exp;
    cyc++;
    chk(!(mem_rd && mem_wr), "R10 strobes exclusive", {mem_rd, mem_wr}, 0);
    if (chk_capt) begin
      chk(instr == last_instr, "R4 IR unchanged in capture step", instr, last_instr);
      chk_capt = 1'b0;
    end
    if (irq_ack)
      chk(prev_done, "R8/R9 ack only after done", 0, 1);
    if (mem_wr) begin
      chk(mem_addr == '0, "R9 save address", mem_addr, 0);
      chk(mem_wdata == DW'(save_exp), "R9 saved pc", mem_wdata, save_exp);
    end
    if (mem_rd) begin
      if (rd_cnt == 0) begin
        chk(mem_addr == pc_exp, "R2 first read address", mem_addr, pc_exp);
        chk_capt = 1'b1;
      end else begin
        chk(mem_addr == mem[pc_exp][AW-1:0], "R6 operand address", mem_addr, mem[pc_exp][AW-1:0]);
      end
      rd_cnt++;
    end
    if (fetch_done) begin
      iw = mem[pc_exp];
      op_exp = iw[AW] ? {{(DW-AW){1'b0}}, iw[AW-1:0]} : mem[iw[AW-1:0]];
      len_exp = (iw[AW] ? 5 : 8) + (taken ? 2 : 0);
      chk(instr == iw, "R7 instruction", instr, iw);
      chk(operand == op_exp, iw[AW] ? "R5 immediate operand" : "R6 memory operand", operand, op_exp);
      chk(rd_cnt == (iw[AW] ? 1 : 2), iw[AW] ? "R5 read count" : "R6 read count", rd_cnt, iw[AW] ? 1 : 2);
      if (!first)
        chk(cyc == len_exp, "R5/R6/R8/R9 cycles between done", cyc, len_exp);
      chk(pc == pc_exp + AW'(1), "R3 pc incremented", pc, pc_exp + AW'(1));
      pc_exp = pc_exp + AW'(1);
      last_instr = iw;
      taken = (irq == 1'b1);
      if (taken) begin
        save_exp = pc_exp;
        pc_exp = AW'(1);
      end
      first = 1'b0;
      cyc = 0;
      rd_cnt = 0;
      dones++;
    end
    prev_done = fetch_done;
  end

  task automatic reset_check();
    chk(pc == '0, "R1 pc in reset", pc, 0);
    chk(instr == '0, "R1 instr in reset", instr, 0);
    chk({mem_rd, mem_wr, fetch_done, irq_ack} == 4'b0, "R1 strobes in reset",
        {mem_rd, mem_wr, fetch_done, irq_ack}, 0);
  endtask

  initial begin
    irq = 1'b0;
    @(posedge rst_n);
    forever begin
      repeat (9 + (irq_gap * 5) % 17) @(posedge clk);
      #2 irq = 1'b1;
      while (irq_ack !== 1'b1) begin
        @(posedge clk);
        #2;
      end
      irq = 1'b0;
      irq_gap++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", dones, 400);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int a = 0; a < DEPTH; a++)
      mem[a] = {4'(a) ^ 4'h5, 1'((a % 3) != 0), 11'((a * 37 + 5) % DEPTH)};
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 reset_check();
    @(posedge clk);
    #2 rst_n = 1'b1;
    wait (dones >= 200);
    @(posedge clk);
    #2 rst_n = 1'b0;
    #1 reset_check();
    first = 1'b1;
    taken = 1'b0;
    rd_cnt = 0;
    chk_capt = 1'b0;
    pc_exp = '0;
    last_instr = '0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    wait (dones >= 400);
    @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule